// File: doc/BRIEF.md
# I2C Pin Recovery Multiplexer

This block sits between an I2C engine's open-drain drive of SCL and SDA and the two pads. In normal operation the engine's pull-down requests go straight to the pads. When a slave has wedged the bus, firmware sets one mode bit and both pins come under software control. It can then clock SCL by hand and watch SDA until the line frees, and clear the mode bit to hand the pins back.

Software sees five word addresses on a simple synchronous write port with combinational read data. Address 0 holds the mode bit (bit 0, 1 = software control). Address 1 holds the per-pin drive enables. Address 2 returns the synchronized pad levels. Address 3 is a write-1-to-release port and address 4 is a write-1-to-pull port for the output latches. A read of address 3 or 4 returns the latches. In every pin vector bit 0 is SCL and bit 1 is SDA. A `pad_pull_low` bit of 1 means the pad is actively pulled low, and 0 means it is released.

Top module: `i2c_pin_recovery_mux`

## Requirements
- R1: After reset the mode bit is 0, both drive enables are 0, both output latches are 1, and both synchronized levels read 1.
- R2: With the mode bit at 0, `pad_pull_low` equals `eng_pull_low` for each pin. In every mode `eng_pin_in` equals `pad_in`.
- R3: With the mode bit at 1, `eng_pull_low` has no effect on `pad_pull_low`.
- R4: Address 1 bit 0 enables driving SCL and bit 1 enables driving SDA. In software mode a pin whose enable is 0 is released, whatever its latch holds.
- R5: Writing address 3 sets to 1 each latch whose data bit is 1 (bit 0 SCL, bit 1 SDA). Latches whose data bit is 0 keep their value.
- R6: Writing address 4 sets to 0 each latch whose data bit is 1. Latches whose data bit is 0 keep their value.
- R7: In software mode a pin with its enable at 1 is pulled low exactly when its latch is 0. A latch of 1 releases the line.
- R8: Address 2 bit 0 gives the SCL pad level and bit 1 the SDA pad level. Each passes through two flops, so a pad change sampled at one rising edge reads back after the next rising edge.
- R9: Addresses 0 and 1 read back the value last written to them. Addresses 3 and 4 read the latches. Any other address and all unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| eng_pull_low | input | 2 | Engine pull-down request (bit 0 SCL, bit 1 SDA) |
| eng_pin_in | output | 2 | Pad levels passed to the engine |
| pad_in | input | 2 | Pad levels |
| pad_pull_low | output | 2 | Pad pull-down enable |

## Verification
On every cycle the assertions check the routing of each pad in both modes, that no undriven pin is ever pulled, and the effect of each set or release write on the latched bits. They also check the two-edge delay of the level readback. Only the bench scenarios can show a complete recovery: nine hand-driven SCL pulses against a slave that holds SDA low, the level readback following the pad through the synchronizer, and the return to engine control. The bench reference model also compares every output and every read address on every clock.

// File: rtl/i2c_pinmux_pkg.sv
package i2c_pinmux_pkg;
  localparam int NPINS   = 2;
  localparam int PIN_SCL = 0;
  localparam int PIN_SDA = 1;

  localparam int ADR_MODE  = 0;
  localparam int ADR_DIR   = 1;
  localparam int ADR_LEVEL = 2;
  localparam int ADR_SET   = 3;
  localparam int ADR_CLR   = 4;

  typedef logic [NPINS-1:0] pinvec_t;

  // New latch value after a release mask and a pull mask
  function automatic pinvec_t latch_next(pinvec_t cur, pinvec_t rel, pinvec_t pull);
    return (cur | rel) & ~pull;
  endfunction

  // Open-drain pull-down for one pin
  function automatic logic pin_pull(logic sw_mode, logic drive_en, logic lat, logic eng);
    if (!sw_mode) return eng;
    return drive_en & ~lat;
  endfunction
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import i2c_pinmux_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              sw_mode,
  output pinvec_t           drive_en,
  output pinvec_t           out_lat,
  output logic              wr_rel_hit,
  output logic              wr_pull_hit
);
  logic wr_mode_hit, wr_dir_hit;
  pinvec_t mask;

  assign mask        = reg_wdata[NPINS-1:0];
  assign wr_mode_hit = reg_wr && (reg_addr == ADDR_W'(ADR_MODE));
  assign wr_dir_hit  = reg_wr && (reg_addr == ADDR_W'(ADR_DIR));
  assign wr_rel_hit  = reg_wr && (reg_addr == ADDR_W'(ADR_SET));
  assign wr_pull_hit = reg_wr && (reg_addr == ADDR_W'(ADR_CLR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_mode  <= 1'b0;
      drive_en <= '0;
      out_lat  <= '1;
    end else begin
      if (wr_mode_hit) sw_mode <= reg_wdata[0];
      if (wr_dir_hit)  drive_en <= mask;
      if (wr_rel_hit)  out_lat <= latch_next(out_lat, mask, '0);
      if (wr_pull_hit) out_lat <= latch_next(out_lat, '0, mask);
    end
  end
endmodule

// File: rtl/pinmux_sync.sv
module pinmux_sync
  import i2c_pinmux_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  pinvec_t raw,
  output pinvec_t synced
);
  pinvec_t st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '1;
    end else begin
      st[0] <= raw;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign synced = st[STAGES-1];
endmodule

// File: rtl/pinmux_pad.sv
module pinmux_pad
  import i2c_pinmux_pkg::*;
(
  input  logic    sw_mode,
  input  pinvec_t drive_en,
  input  pinvec_t out_lat,
  input  pinvec_t eng_pull,
  output pinvec_t pad_pull
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign pad_pull[p] = pin_pull(sw_mode, drive_en[p], out_lat[p], eng_pull[p]);
  end
endmodule

// File: rtl/i2c_pin_recovery_mux.sv
module i2c_pin_recovery_mux
  import i2c_pinmux_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [1:0]        eng_pull_low,
  output logic [1:0]        eng_pin_in,
  input  logic [1:0]        pad_in,
  output logic [1:0]        pad_pull_low
);
  localparam int PAD_W = DATA_W - NPINS;

  logic    sw_mode;
  pinvec_t drive_en, out_lat, lvl_sync;
  logic    wr_rel_hit, wr_pull_hit;

  pinmux_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sw_mode(sw_mode), .drive_en(drive_en),
    .out_lat(out_lat), .wr_rel_hit(wr_rel_hit), .wr_pull_hit(wr_pull_hit)
  );

  pinmux_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pad_in), .synced(lvl_sync)
  );

  pinmux_pad u_pad (
    .sw_mode(sw_mode), .drive_en(drive_en), .out_lat(out_lat),
    .eng_pull(eng_pull_low), .pad_pull(pad_pull_low)
  );

  assign eng_pin_in = pad_in;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(ADR_MODE):  reg_rdata = {{(DATA_W-1){1'b0}}, sw_mode};
      ADDR_W'(ADR_DIR):   reg_rdata = {{PAD_W{1'b0}}, drive_en};
      ADDR_W'(ADR_LEVEL): reg_rdata = {{PAD_W{1'b0}}, lvl_sync};
      ADDR_W'(ADR_SET),
      ADDR_W'(ADR_CLR):   reg_rdata = {{PAD_W{1'b0}}, out_lat};
      default:            reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_pin_recovery_mux_chk.sv
module i2c_pin_recovery_mux_chk #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [1:0]        eng_pull_low,
  input logic [1:0]        pad_in,
  input logic [1:0]        pad_pull_low,
  input logic              sw_mode,
  input logic [1:0]        drive_en,
  input logic [1:0]        out_lat,
  input logic [1:0]        lvl_sync,
  input logic              wr_rel_hit,
  input logic              wr_pull_hit
);
  logic [1:0] edges;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= '0;
    else if (edges != 2'd3) edges <= edges + 2'd1;
  end

  assert_eng_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_mode |-> (pad_pull_low == eng_pull_low));

  assert_undriven_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_mode |-> ((pad_pull_low & ~drive_en) == 2'b00));

  assert_open_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_mode && drive_en == 2'b11) |-> (pad_pull_low == ~out_lat));

  assert_rel_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rel_hit |=> ((out_lat & $past(reg_wdata[1:0])) == $past(reg_wdata[1:0])));

  assert_rel_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rel_hit |=> (((out_lat ^ $past(out_lat)) & ~$past(reg_wdata[1:0])) == 2'b00));

  assert_pull_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pull_hit |=> ((out_lat & $past(reg_wdata[1:0])) == 2'b00));

  assert_pull_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pull_hit |=> (((out_lat ^ $past(out_lat)) & ~$past(reg_wdata[1:0])) == 2'b00));

  // Fixed two-flop depth: checked only for the default synchronizer length
  if (SYNC_STAGES == 2) begin : g_sync2
    assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (edges >= 2'd2) |-> (lvl_sync == $past(pad_in, 2)));
  end
endmodule

bind i2c_pin_recovery_mux i2c_pin_recovery_mux_chk #(
  .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wdata(reg_wdata),
  .eng_pull_low(eng_pull_low), .pad_in(pad_in), .pad_pull_low(pad_pull_low),
  .sw_mode(sw_mode), .drive_en(drive_en), .out_lat(out_lat),
  .lvl_sync(lvl_sync), .wr_rel_hit(wr_rel_hit), .wr_pull_hit(wr_pull_hit)
);

// File: tb/i2c_pin_recovery_mux_bench.sv
`timescale 1ns/1ps
module i2c_pin_recovery_mux_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [1:0] eng_pull_low = 2'b00;
  logic [1:0] eng_pin_in;
  logic [1:0] ext_hold = 2'b11;
  logic [1:0] pad_in;
  logic [1:0] pad_pull_low;

  int total = 0;
  int bad = 0;
  bit started = 0;
  bit finished = 0;

  // reference model state
  int m_mode, m_dir, m_lat, m_s1, m_s2;

  always #4 clk = ~clk;

  assign pad_in = ext_hold & ~pad_pull_low;

  i2c_pin_recovery_mux u_i2c_pin_recovery_mux (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_pull_low(eng_pull_low),
    .eng_pin_in(eng_pin_in), .pad_in(pad_in), .pad_pull_low(pad_pull_low)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_pull(int p);
    if (m_mode == 0) return eng_pull_low[p];
    return ((m_dir >> p) & 1) & (((m_lat >> p) & 1) ^ 1);
  endfunction

  function automatic string pull_tag(int p);
    if (m_mode == 0) return "R2";
    if (((m_dir >> p) & 1) == 0) return "R4";
    return "R7";
  endfunction

  function automatic int exp_read(int a);
    case (a)
      0: return m_mode;
      1: return m_dir;
      2: return m_s2;
      3, 4: return m_lat;
      default: return 0;
    endcase
  endfunction

  function automatic string read_tag(int a);
    case (a)
      2: return "R8";
      3: return "R5";
      4: return "R6";
      default: return "R9";
    endcase
  endfunction

  // per-cycle model update and comparison
  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_mode = 0; m_dir = 0; m_lat = 3; m_s1 = 3; m_s2 = 3;
      started = 1;
    end else begin
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_mode = reg_wdata[0];
          3'd1: m_dir = reg_wdata[1:0];
          3'd3: m_lat = m_lat | reg_wdata[1:0];
          3'd4: m_lat = m_lat & ~int'(reg_wdata[1:0]) & 3;
          default: ;
        endcase
      end
    end
    #2;
    if (started && rst_n && !finished) begin
      for (int p = 0; p < 2; p++) chk(pull_tag(p), pad_pull_low[p], exp_pull(p));
      chk("R2", eng_pin_in, pad_in);
      chk(read_tag(reg_addr), reg_rdata, exp_read(reg_addr));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, string tag, int exp);
    @(negedge clk);
    reg_addr = 3'(a);
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog: actual=timeout expected=done");
    bad++; total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, "R1", 0);
    rd(1, "R1", 0);
    rd(3, "R1", 3);
    rd(2, "R1", 3);
    #1 chk("R1", pad_pull_low, 0);

    // R2 engine routing
    for (int v = 0; v < 4; v++) begin
      @(negedge clk); eng_pull_low = 2'(v);
      #1 chk("R2", pad_pull_low, v);
    end
    eng_pull_low = 2'b11;

    // R3 software mode, drive disabled: engine ignored, pins released (R4)
    wr(0, 1);
    #1 chk("R3", pad_pull_low, 0);
    wr(4, 3);
    #1 chk("R4", pad_pull_low, 0);
    wr(3, 3);

    // R7 enable SCL drive only, pull SCL
    wr(1, 1);
    wr(4, 1);
    #1 chk("R7", pad_pull_low, 1);
    rd(1, "R9", 1);
    // R8 level readback after two edges: SCL low
    settle(2);
    rd(2, "R8", 2);
    // R5 zero bits ignored
    wr(3, 8'hFC);
    rd(3, "R5", 2);
    // R6 zero bits ignored
    wr(4, 8'hFC);
    rd(4, "R6", 2);
    wr(3, 1);
    rd(3, "R5", 3);

    // stuck slave holds SDA; nine SCL pulses
    @(negedge clk); ext_hold = 2'b01;
    settle(3);
    rd(2, "R8", 1);
    for (int k = 0; k < 9; k++) begin
      wr(4, 1);
      #1 chk("R7", pad_pull_low, 1);
      wr(3, 1);
      #1 chk("R7", pad_pull_low, 0);
      if (k == 6) ext_hold = 2'b11;
    end
    settle(3);
    rd(2, "R8", 3);

    // SDA drive: enable both, pull SDA
    wr(1, 3);
    wr(4, 2);
    #1 chk("R7", pad_pull_low, 2);
    settle(2);
    rd(2, "R8", 1);
    wr(1, 1);
    #1 chk("R4", pad_pull_low, 0);

    // R9 unused addresses
    rd(5, "R9", 0);
    rd(7, "R9", 0);
    wr(2, 0);
    rd(1, "R9", 1);

    // back to engine
    wr(0, 0);
    @(negedge clk); eng_pull_low = 2'b10;
    #1 chk("R2", pad_pull_low, 2);
    rd(0, "R9", 0);
    settle(4);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule